// File: doc/BRIEF.md
# PDM Silence-Pattern Mode Controller

This block decides the operating mode of a class-D output stage from what arrives on a one-bit PDM audio input. It watches the PDM data line and the PDM clock. The stream is cut into bytes, and a long run of one of two reserved byte values puts the stage into power-down or mute. Any other byte returns the stage to normal operation. If the PDM clock stops, the block also selects power-down. An external protection indication overrides everything else and forces fault mode.

All logic runs on an always-on reference clock. That clock must be several times faster than the PDM clock. The PDM clock and data pins are brought in through two-flop synchronizers. A rising edge seen on the synchronized clock takes one data bit. The block produces:
- a 2-bit mode code;
- an output-stage enable, which is high only while the stage may switch;
- a one-cycle pulse on every mode change.

The PDM stream cannot be held back. For that reason the bit input has no valid/ready handshake. Every rising PDM edge delivers one bit, and the block never asserts back-pressure. The fault input is taken as synchronous to the reference clock.

Top module: `pdm_mode_ctrl`

## Requirements
- R1: After reset the mode code is 2'b00 (power-down), `out_en` is 0 and `mode_chg` is 0. The mode stays power-down until the first PDM clock edges arrive.
- R2: One data bit is taken at each rising PDM clock edge. Each group of 8 bits forms one byte, with the first bit received as the MSB. For example, 128 bytes sent as 0x35 (0xAC in reversed bit order) do not select power-down.
- R3: The mode becomes power-down (2'b00) as soon as the 128th consecutive byte equal to 0xAC completes. After 127 such bytes the mode is still operating.
- R4: Power-down holds while every further byte is 0xAC. The first byte of any other value returns the mode to operating (2'b10).
- R5: The mode becomes mute (2'b01) as soon as the 32nd consecutive byte equal to 0x66 completes. After 31 such bytes the mode is unchanged.
- R6: Mute holds until a byte other than 0x66 arrives, and then the mode returns to operating.
- R7: If no PDM clock edge is seen for `LOSS_CYCLES` reference cycles, the mode becomes power-down. The byte framer then restarts, so the first bit after the clock resumes is the MSB of a new byte. When edges return, the mode becomes operating, or mute if the mute run is still complete.
- R8: A high `fault_in` gives mode 2'b11 one cycle later. Fault holds after `fault_in` falls until the second byte boundary that follows, so at least one whole byte is received fault-free.
- R9: Priority from highest to lowest is fault, clock loss, power-down run, mute run, operating.
- R10: `out_en` is 1 only when the mode is operating (2'b10). It is 0 in power-down, mute and fault.
- R11: `mode_chg` pulses for exactly one cycle, in the cycle the new mode code first appears. It is 0 at all other times.
- R12: A byte that does not match the pattern restarts that pattern's run count. For example, 31 × 0x66, then 0x00, then 31 × 0x66 leaves the mode operating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Always-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdm_clk | input | 1 | PDM bit clock, sampled through a synchronizer |
| pdm_data | input | 1 | PDM data, taken at rising PDM clock edges |
| fault_in | input | 1 | Protection indication, synchronous to ref_clk |
| mode | output | 2 | 00 power-down, 01 mute, 10 operating, 11 fault |
| out_en | output | 1 | Output stage switching enable |
| mode_chg | output | 1 | One-cycle pulse on each mode change |

## Verification
The hardest state to reach from the pins combines a clock stop in the middle of a byte with a silence run that is already complete. The bench sends three stray bits and then holds the PDM clock low past the timeout. After that it sends an aligned 0x66 run. Mute is reached only if the framer realigned to the first bit after the clock resumed. A second case leaves the mute run complete before the clock stops. This checks that resumption goes back to mute rather than to operating. Fault release is tested by dropping `fault_in` just after a byte boundary and counting exactly two further bytes.

// File: rtl/pdm_mode_pkg.sv
package pdm_mode_pkg;
  typedef enum logic [1:0] {
    MODE_PDOWN = 2'b00,
    MODE_MUTE  = 2'b01,
    MODE_OPER  = 2'b10,
    MODE_FAULT = 2'b11
  } mode_e;

  localparam int unsigned BYTE_W        = 8;
  localparam logic [7:0]  PDOWN_PATTERN = 8'hAC;
  localparam logic [7:0]  MUTE_PATTERN  = 8'h66;
endpackage

// File: rtl/pdm_front.sv
module pdm_front #(
  parameter int unsigned LOSS_CYCLES = 64
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic pdm_clk,
  input  logic pdm_data,
  output logic bit_stb,
  output logic bit_val,
  output logic clk_lost
);
  localparam int unsigned GW = (LOSS_CYCLES > 1) ? $clog2(LOSS_CYCLES) : 1;
  localparam logic [GW-1:0] GAP_LAST = GW'(LOSS_CYCLES - 1);

  logic [2:0]    clk_sync;
  logic [1:0]    dat_sync;
  logic [GW-1:0] gap_cnt;
  logic          any_edge;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sync <= '0;
      dat_sync <= '0;
    end else begin
      clk_sync <= {clk_sync[1:0], pdm_clk};
      dat_sync <= {dat_sync[0], pdm_data};
    end
  end

  assign bit_stb  = clk_sync[1] & ~clk_sync[2];
  assign bit_val  = dat_sync[1];
  assign any_edge = clk_sync[1] ^ clk_sync[2];

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt  <= '0;
      clk_lost <= 1'b1;
    end else if (any_edge) begin
      gap_cnt  <= '0;
      clk_lost <= 1'b0;
    end else if (gap_cnt == GAP_LAST) begin
      clk_lost <= 1'b1;
    end else begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pdm_byte_framer.sv
module pdm_byte_framer #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic              resync,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_data
);
  localparam int unsigned CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST_BIT = CW'(BYTE_W - 1);

  logic [CW-1:0]     bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] shnext;

  assign shnext = {shreg[BYTE_W-2:0], bit_val};

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      shreg     <= '0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (bit_stb) begin
        shreg   <= shnext;
        bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
        if (bit_cnt == LAST_BIT) begin
          byte_vld  <= 1'b1;
          byte_data <= shnext;
        end
      end else if (resync) begin
        bit_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/pdm_run_detect.sv
module pdm_run_detect #(
  parameter int unsigned BYTE_W  = 8,
  parameter logic [7:0]  PATTERN = 8'hAC,
  parameter int unsigned RUN_LEN = 128
) (
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              active
);
  localparam int unsigned CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(RUN_LEN);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (byte_vld) begin
      if (byte_data == BYTE_W'(PATTERN)) begin
        if (run_cnt != CNT_MAX) run_cnt <= run_cnt + 1'b1;
      end else begin
        run_cnt <= '0;
      end
    end
  end

  assign active = (run_cnt == CNT_MAX);
endmodule

// File: rtl/pdm_mode_ctrl.sv
module pdm_mode_ctrl
  import pdm_mode_pkg::*;
#(
  parameter int unsigned PDOWN_RUN   = 128,
  parameter int unsigned MUTE_RUN    = 32,
  parameter int unsigned LOSS_CYCLES = 64
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       pdm_clk,
  input  logic       pdm_data,
  input  logic       fault_in,
  output logic [1:0] mode,
  output logic       out_en,
  output logic       mode_chg
);
  logic              bit_stb;
  logic              bit_val;
  logic              clk_lost;
  logic              byte_vld;
  logic [BYTE_W-1:0] byte_data;
  logic              pdown_active;
  logic              mute_active;
  logic              fault_hold;
  logic              fault_armed;
  mode_e             mode_q;
  mode_e             mode_d;

  pdm_front #(.LOSS_CYCLES(LOSS_CYCLES)) u_front (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .pdm_clk (pdm_clk),
    .pdm_data(pdm_data),
    .bit_stb (bit_stb),
    .bit_val (bit_val),
    .clk_lost(clk_lost)
  );

  pdm_byte_framer #(.BYTE_W(BYTE_W)) u_framer (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .bit_stb  (bit_stb),
    .bit_val  (bit_val),
    .resync   (clk_lost),
    .byte_vld (byte_vld),
    .byte_data(byte_data)
  );

  pdm_run_detect #(
    .BYTE_W(BYTE_W), .PATTERN(PDOWN_PATTERN), .RUN_LEN(PDOWN_RUN)
  ) u_pdown_run (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .byte_vld (byte_vld),
    .byte_data(byte_data),
    .active   (pdown_active)
  );

  pdm_run_detect #(
    .BYTE_W(BYTE_W), .PATTERN(MUTE_PATTERN), .RUN_LEN(MUTE_RUN)
  ) u_mute_run (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .byte_vld (byte_vld),
    .byte_data(byte_data),
    .active   (mute_active)
  );

  // Fault is released at the second byte boundary after the input drops.
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_hold  <= 1'b0;
      fault_armed <= 1'b0;
    end else if (fault_in) begin
      fault_hold  <= 1'b1;
      fault_armed <= 1'b0;
    end else if (fault_hold && byte_vld) begin
      if (fault_armed) begin
        fault_hold  <= 1'b0;
        fault_armed <= 1'b0;
      end else begin
        fault_armed <= 1'b1;
      end
    end
  end

  always_comb begin
    if (fault_in || fault_hold) mode_d = MODE_FAULT;
    else if (clk_lost)          mode_d = MODE_PDOWN;
    else if (pdown_active)      mode_d = MODE_PDOWN;
    else if (mute_active)       mode_d = MODE_MUTE;
    else                        mode_d = MODE_OPER;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_PDOWN;
      out_en   <= 1'b0;
      mode_chg <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      out_en   <= (mode_d == MODE_OPER);
      mode_chg <= (mode_d != mode_q);
    end
  end

  assign mode = mode_q;
endmodule

// File: rtl/pdm_mode_ctrl_sva.sv
module pdm_mode_ctrl_sva (
  input logic       ref_clk,
  input logic       rst_n,
  input logic       fault_in,
  input logic [1:0] mode,
  input logic       out_en,
  input logic       mode_chg,
  input logic       clk_lost,
  input logic       fault_hold,
  input logic       byte_vld,
  input logic [7:0] byte_data,
  input logic       mute_active
);
  assert_fault_forced_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    fault_in |=> (mode == 2'b11));

  assert_no_enable_in_fault_R10: assert property (@(posedge ref_clk) disable iff (!rst_n)
    fault_in |=> !out_en);

  assert_enable_only_oper_R10: assert property (@(posedge ref_clk) disable iff (!rst_n)
    out_en |-> (mode == 2'b10));

  assert_pulse_on_change_R11: assert property (@(posedge ref_clk) disable iff (!rst_n)
    mode_chg |-> (mode != $past(mode)));

  assert_no_silent_change_R11: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !mode_chg |-> $stable(mode));

  assert_loss_forces_pdown_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (clk_lost && !fault_in && !fault_hold) |=> (mode == 2'b00));

  assert_mismatch_restarts_R12: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (byte_vld && byte_data != 8'h66) |=> !mute_active);
endmodule

bind pdm_mode_ctrl pdm_mode_ctrl_sva u_sva (
  .ref_clk    (ref_clk),
  .rst_n      (rst_n),
  .fault_in   (fault_in),
  .mode       (mode),
  .out_en     (out_en),
  .mode_chg   (mode_chg),
  .clk_lost   (clk_lost),
  .fault_hold (fault_hold),
  .byte_vld   (byte_vld),
  .byte_data  (byte_data),
  .mute_active(mute_active)
);

// File: tb/pdm_mode_ctrl_test.sv
`timescale 1ns/1ps
module pdm_mode_ctrl_test;
  localparam logic [1:0] PD = 2'b00, MU = 2'b01, OP = 2'b10, FT = 2'b11;

  logic       ref_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pdm_clk = 1'b0;
  logic       pdm_data = 1'b0;
  logic       fault_in = 1'b0;
  logic [1:0] mode;
  logic       out_en;
  logic       mode_chg;
  int         vectors = 0;
  int         miscompares = 0;
  int         pulses = 0;

  always #2.5 ref_clk = ~ref_clk;

  always @(posedge ref_clk) if (rst_n && mode_chg) pulses++;

  pdm_mode_ctrl uut (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .pdm_clk (pdm_clk),
    .pdm_data(pdm_data),
    .fault_in(fault_in),
    .mode    (mode),
    .out_en  (out_en),
    .mode_chg(mode_chg)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge ref_clk) pdm_data = b;
    repeat (4) @(negedge ref_clk);
    pdm_clk = 1'b1;
    repeat (4) @(negedge ref_clk);
    pdm_clk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    repeat (6) @(negedge ref_clk);
  endtask

  task automatic send_run(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) send_byte(v);
  endtask

  task automatic t_reset;
    chk("R1 reset mode", mode, PD);
    chk("R1 reset out_en", out_en, 0);
    chk("R1 reset mode_chg", mode_chg, 0);
    repeat (20) @(negedge ref_clk);
    chk("R1 no clock yet", mode, PD);
    send_run(8'h00, 2);
    chk("R1 operating after clock", mode, OP);
    chk("R10 out_en operating", out_en, 1);
  endtask

  task automatic t_powerdown;
    send_run(8'hAC, 127);
    chk("R3 127 bytes not enough", mode, OP);
    pulses = 0;
    send_byte(8'hAC);
    chk("R3 128th byte", mode, PD);
    chk("R10 out_en power-down", out_en, 0);
    chk("R11 single pulse", pulses, 1);
    send_run(8'hAC, 3);
    chk("R4 held by more 0xAC", mode, PD);
    pulses = 0;
    send_byte(8'h12);
    chk("R4 exit on other byte", mode, OP);
    chk("R11 single pulse exit", pulses, 1);
  endtask

  task automatic t_bitorder;
    send_run(8'h35, 128);
    chk("R2 reversed pattern ignored", mode, OP);
  endtask

  task automatic t_mute;
    send_run(8'h66, 31);
    chk("R5 31 bytes not enough", mode, OP);
    send_byte(8'h00);
    send_run(8'h66, 31);
    chk("R12 interrupted run", mode, OP);
    send_byte(8'h66);
    chk("R5 32nd byte", mode, MU);
    chk("R10 out_en mute", out_en, 0);
    send_run(8'h66, 2);
    chk("R6 mute held", mode, MU);
    // fault over mute
    @(negedge ref_clk) fault_in = 1'b1;
    repeat (2) @(negedge ref_clk);
    chk("R9 fault over mute", mode, FT);
    send_byte(8'h66);
    @(negedge ref_clk) fault_in = 1'b0;
    send_byte(8'h66);
    chk("R8 held after first boundary", mode, FT);
    send_byte(8'h66);
    chk("R9 back to mute after fault", mode, MU);
    // clock loss over complete mute run
    repeat (100) @(negedge ref_clk);
    chk("R9 clock loss over mute", mode, PD);
    send_byte(8'h66);
    chk("R7 resume into mute", mode, MU);
    send_byte(8'h01);
    chk("R6 exit mute", mode, OP);
  endtask

  task automatic t_fault;
    @(negedge ref_clk) fault_in = 1'b1;
    repeat (2) @(negedge ref_clk);
    chk("R8 fault mode", mode, FT);
    chk("R10 out_en fault", out_en, 0);
    send_byte(8'h00);
    @(negedge ref_clk) fault_in = 1'b0;
    send_byte(8'h00);
    chk("R8 still fault", mode, FT);
    send_byte(8'h00);
    chk("R8 released", mode, OP);
  endtask

  task automatic t_loss;
    repeat (30) @(negedge ref_clk);
    chk("R7 short gap tolerated", mode, OP);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    repeat (100) @(negedge ref_clk);
    chk("R7 clock loss", mode, PD);
    send_run(8'h66, 32);
    chk("R7 framer realigned", mode, MU);
    send_byte(8'h00);
    chk("R7 operating after resume", mode, OP);
  endtask

  initial begin
    #(200000 * 5.0);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (4) @(negedge ref_clk);
    rst_n = 1'b1;
    @(negedge ref_clk);
    t_reset();
    t_powerdown();
    t_bitorder();
    t_mute();
    t_fault();
    t_loss();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule